// File: doc/BRIEF.md
# Command-Port Static RAM Interface

This block connects a host with very few spare pins to a 256K-byte asynchronous static RAM. The host uses one 8-bit data port and two control lines. The first control line chooses the destination of a strobe. The second line is the strobe itself, and the port value is taken when the strobe falls. With the selector low, the strobe loads an 8-bit command register. With the selector high, the strobe acts on whatever the current command names: one of the three address fields, a RAM write, or a RAM read.

The 18-bit address is held in three fields: 2 top bits, a middle byte and a low byte. Each field keeps its value until it is loaded again. A host stepping through memory therefore reloads only the fields that differ from the previous access. The address never moves on by itself. A write runs a fixed three-cycle sequence toward the RAM. A read places RAM data on the host port for as long as the strobe is held high. The port pad's tri-state buffer sits at the chip edge and is controlled by the output-enable pin.

The two control lines pass through a synchronizer chain. A strobe takes effect a few clock cycles after its falling edge, so the host must hold the port and the selector steady for that long.

Top module: `sram_cmd_port`

## Requirements
- R1: While reset is asserted and directly after it, `sram_addr` is 0, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are 1, and `host_dout_en` is 0.
- R2: A strobe (`host_stb` high, then low) with `host_sel` = 0 loads `host_din` into the command register. The load happens no later than 3 clock cycles after the falling edge of the strobe.
- R3: A strobe with `host_sel` = 1 acts on the current command as follows. Command 0x01 loads address bits 17:16 from port bits 1:0. Command 0x02 loads bits 15:8. Command 0x03 loads bits 7:0. The other address bits are unchanged.
- R4: An address field not reloaded keeps its value across any number of reads and writes. The address never advances by itself.
- R5: Under command 0x04, a target strobe writes its port byte to the current address. `sram_ce_n` and `sram_we_n` go low together for exactly one cycle, and `sram_oe_n` stays 1.
- R6: `sram_addr` and `sram_wdata` hold the same value in the cycle before, during and after the write-enable pulse.
- R7: Under command 0x05, while the strobe is high with `host_sel` = 1, `sram_ce_n` and `sram_oe_n` are 0, `host_dout_en` is 1 and `host_dout` equals `sram_rdata`. All three return to idle within 3 cycles after the strobe falls.
- R8: Command codes 0x00 and 0x06 to 0xFF are ignored. A target strobe under such a code leaves the address unchanged, causes no RAM cycle and does not drive the port.
- R9: The command register keeps its value. Repeated target strobes after one command repeat that command, for example two writes after a single 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_din | input | 8 | Host port, value seen from the pad |
| host_dout | output | 8 | Value driven onto the host port during a read |
| host_dout_en | output | 1 | Pad output enable for the host port |
| host_sel | input | 1 | Strobe destination: 0 command register, 1 target of command |
| host_stb | input | 1 | Host strobe, acts on its falling edge |
| sram_addr | output | 18 | RAM address |
| sram_wdata | output | 8 | RAM write data |
| sram_rdata | input | 8 | RAM read data |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |

## Verification
A table of accesses alternates writes and reads, each preceded by reloading a different subset of address fields: all three, none, only the low byte, only the middle byte, only the top bits. This separates a field that is truly retained from one that is reloaded or overwritten by a neighbour. The extreme addresses 0x00000 and 0x3FFFF show that each field lands at its correct bit position. Directed cases then cover three things:
- a command code of 0x00, 0x06 and 0xFF, which must leave address, RAM and port untouched;
- two data strobes after a single write command;
- the port being released after a read strobe ends.

// File: rtl/sram_cmd_pkg.sv
package sram_cmd_pkg;
  typedef enum logic [7:0] {
    CMD_LD_HI  = 8'h01,
    CMD_LD_MID = 8'h02,
    CMD_LD_LO  = 8'h03,
    CMD_WR     = 8'h04,
    CMD_RD     = 8'h05
  } cmd_e;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_SETUP,
    WS_PULSE,
    WS_HOLD
  } wr_st_e;
endpackage

// File: rtl/host_sync.sv
module host_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_in,
  input  logic sel_in,
  output logic stb_s,
  output logic sel_s,
  output logic fall_p
);
  logic [STAGES-1:0] stb_sh_q, stb_sh_d, sel_sh_q, sel_sh_d;
  logic stb_dly_q;

  always_comb begin
    stb_sh_d = {stb_sh_q[STAGES-2:0], stb_in};
    sel_sh_d = {sel_sh_q[STAGES-2:0], sel_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_sh_q  <= '0;
      sel_sh_q  <= '0;
      stb_dly_q <= 1'b0;
    end else begin
      stb_sh_q  <= stb_sh_d;
      sel_sh_q  <= sel_sh_d;
      stb_dly_q <= stb_sh_q[STAGES-1];
    end
  end

  assign stb_s  = stb_sh_q[STAGES-1];
  assign sel_s  = sel_sh_q[STAGES-1];
  assign fall_p = stb_dly_q & ~stb_s;

  // R2
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_p |=> !fall_p);
endmodule

// File: rtl/cmd_regs.sv
module cmd_regs
  import sram_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_p,
  input  logic              sel_s,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] cmd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wr_req
);
  localparam int unsigned HI_W = ADDR_W - 2*DATA_W;

  logic              cmd_en, tgt_en, hi_en, mid_en, lo_en;
  logic [DATA_W-1:0] cmd_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    cmd_en = fall_p & ~sel_s;
    tgt_en = fall_p & sel_s;
    hi_en  = tgt_en && (cmd_q == DATA_W'(CMD_LD_HI));
    mid_en = tgt_en && (cmd_q == DATA_W'(CMD_LD_MID));
    lo_en  = tgt_en && (cmd_q == DATA_W'(CMD_LD_LO));
    wr_req = tgt_en && (cmd_q == DATA_W'(CMD_WR));
    cmd_d  = cmd_en ? din : cmd_q;
    addr_d = addr_q;
    if (hi_en)  addr_d[ADDR_W-1 -: HI_W]   = din[HI_W-1:0];
    if (mid_en) addr_d[2*DATA_W-1 -: DATA_W] = din;
    if (lo_en)  addr_d[DATA_W-1:0]          = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
    end
  end

  // R4
  addr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_p |=> $stable(addr_q));
  // R8
  bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_p && sel_s && (cmd_q == 8'h00 || cmd_q > 8'h05)) |=> $stable(addr_q));
  // R9
  cmd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_p && sel_s) |=> $stable(cmd_q));
endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_cmd_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] wdata_q,
  output logic              pulse,
  output logic              busy
);
  wr_st_e            st_q, st_d;
  logic [DATA_W-1:0] wdata_d;

  always_comb begin
    st_d    = st_q;
    wdata_d = wdata_q;
    unique case (st_q)
      WS_IDLE: if (wr_req) begin
        st_d    = WS_SETUP;
        wdata_d = din;
      end
      WS_SETUP: st_d = WS_PULSE;
      WS_PULSE: st_d = WS_HOLD;
      WS_HOLD:  st_d = WS_IDLE;
      default:  st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WS_IDLE;
      wdata_q <= '0;
    end else begin
      st_q    <= st_d;
      wdata_q <= wdata_d;
    end
  end

  assign pulse = (st_q == WS_PULSE);
  assign busy  = (st_q != WS_IDLE);

  // R5
  pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> $stable(wdata_q));
  // R6
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $stable(wdata_q));
endmodule

// File: rtl/sram_cmd_port.sv
module sram_cmd_port
  import sram_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 18,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] host_din,
  output logic [DATA_W-1:0] host_dout,
  output logic              host_dout_en,
  input  logic              host_sel,
  input  logic              host_stb,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n
);
  logic              rst_meta_q, rst_q;
  logic              stb_s, sel_s, fall_p, wr_req, wr_pulse, wr_busy, rd_act;
  logic [DATA_W-1:0] cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  host_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q), .stb_in(host_stb), .sel_in(host_sel),
    .stb_s(stb_s), .sel_s(sel_s), .fall_p(fall_p)
  );

  cmd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_q), .fall_p(fall_p), .sel_s(sel_s), .din(host_din),
    .cmd_q(cmd_q), .addr_q(sram_addr), .wr_req(wr_req)
  );

  sram_wr_seq #(.DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_q), .wr_req(wr_req), .din(host_din),
    .wdata_q(sram_wdata), .pulse(wr_pulse), .busy(wr_busy)
  );

  always_comb begin
    rd_act       = stb_s & sel_s & (cmd_q == DATA_W'(CMD_RD)) & ~wr_busy;
    sram_we_n    = ~wr_pulse;
    sram_oe_n    = ~rd_act;
    sram_ce_n    = ~(wr_pulse | rd_act);
    host_dout_en = rd_act;
    host_dout    = sram_rdata;
  end

  // R5
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !(!sram_we_n && !sram_oe_n));
  // R7
  drive_rd_chk: assert property (@(posedge clk) disable iff (!rst_q)
    host_dout_en |-> (!sram_oe_n && !sram_ce_n));
  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !sram_we_n |=> $stable(sram_addr));
  // R6
  addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(sram_we_n) |-> $stable(sram_addr));
endmodule

// File: tb/sim_sram_cmd_port.sv
module sim_sram_cmd_port;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, host_sel, host_stb;
  logic [7:0]  host_din, host_dout, sram_wdata, sram_rdata;
  logic        host_dout_en, sram_ce_n, sram_we_n, sram_oe_n;
  logic [17:0] sram_addr;

  int checks = 0, failures = 0;
  int wcnt = 0, drv_cnt = 0, st_err = 0;
  logic [17:0] cap_addr, prev_addr, exp_addr;
  logic [7:0]  cap_data, prev_data;
  logic        prev_we_n = 1'b1, hold_pend = 1'b0;
  bit          done = 0;

  // vector: op(1=write) | load mask(hi,mid,lo) | hi(2) | mid(8) | lo(8) | data(8)
  localparam logic [29:0] VEC [0:7] = '{
    {1'b1, 3'b111, 2'b10, 8'h34, 8'h56, 8'hA5},
    {1'b0, 3'b000, 2'b00, 8'h00, 8'h00, 8'h00},
    {1'b1, 3'b001, 2'b00, 8'h00, 8'h57, 8'h3C},
    {1'b0, 3'b010, 2'b00, 8'hFF, 8'h00, 8'h00},
    {1'b1, 3'b100, 2'b01, 8'h00, 8'h00, 8'hFF},
    {1'b0, 3'b111, 2'b00, 8'h00, 8'h00, 8'h00},
    {1'b1, 3'b111, 2'b11, 8'hFF, 8'hFF, 8'h00},
    {1'b0, 3'b000, 2'b00, 8'h00, 8'h00, 8'h00}
  };

  sram_cmd_port u0 (
    .clk(clk), .rst_n(rst_n), .host_din(host_din), .host_dout(host_dout),
    .host_dout_en(host_dout_en), .host_sel(host_sel), .host_stb(host_stb),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
  );

  function automatic logic [7:0] mem_val(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {6'd0, a[17:16]} ^ 8'h5A;
  endfunction

  assign sram_rdata = mem_val(sram_addr);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (host_dout_en) drv_cnt++;
    if (!sram_we_n) begin
      wcnt++;
      cap_addr = sram_addr;
      cap_data = sram_wdata;
      if (!prev_we_n || sram_addr != prev_addr || sram_wdata != prev_data) st_err++;
      if (sram_ce_n || !sram_oe_n) st_err++;
      hold_pend = 1'b1;
    end else if (hold_pend) begin
      hold_pend = 1'b0;
      if (sram_addr != prev_addr || sram_wdata != prev_data) st_err++;
    end
    prev_addr = sram_addr;
    prev_data = sram_wdata;
    prev_we_n = sram_we_n;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pstrobe(input logic sel, input logic [7:0] v);
    @(negedge clk);
    host_sel = sel;
    host_din = v;
    @(negedge clk);
    host_stb = 1'b1;
    repeat (3) @(negedge clk);
    host_stb = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_load(input logic [2:0] m, input logic [1:0] hi,
                         input logic [7:0] mid, input logic [7:0] lo);
    if (m[2]) begin pstrobe(1'b0, 8'h01); pstrobe(1'b1, {6'd0, hi}); exp_addr[17:16] = hi; end
    if (m[1]) begin pstrobe(1'b0, 8'h02); pstrobe(1'b1, mid); exp_addr[15:8] = mid; end
    if (m[0]) begin pstrobe(1'b0, 8'h03); pstrobe(1'b1, lo); exp_addr[7:0] = lo; end
  endtask

  task automatic do_write(input logic [7:0] d);
    int w0;
    w0 = wcnt;
    pstrobe(1'b0, 8'h04);
    pstrobe(1'b1, d);
    check(wcnt == w0 + 1, "R5 one write pulse", wcnt - w0, 1);
    check(cap_addr == exp_addr, "R3/R4 write address", cap_addr, exp_addr);
    check(cap_data == d, "R5 write data", cap_data, d);
    check(st_err == 0, "R6 setup/hold", st_err, 0);
  endtask

  task automatic do_read();
    pstrobe(1'b0, 8'h05);
    @(negedge clk);
    host_sel = 1'b1;
    host_din = 8'h00;
    @(negedge clk);
    host_stb = 1'b1;
    repeat (4) @(negedge clk);
    check(host_dout_en && !sram_oe_n && !sram_ce_n, "R7 read drive", host_dout_en, 1);
    check(sram_addr == exp_addr, "R4 read address", sram_addr, exp_addr);
    check(host_dout == mem_val(exp_addr), "R7 read data", host_dout, mem_val(exp_addr));
    host_stb = 1'b0;
    repeat (4) @(negedge clk);
    check(!host_dout_en && sram_oe_n && sram_ce_n, "R7 release", host_dout_en, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_sel = 1'b0; host_stb = 1'b0; host_din = 8'h00;
    exp_addr = '0;
    repeat (3) @(negedge clk);
    check(sram_addr == 0 && sram_ce_n && sram_we_n && sram_oe_n && !host_dout_en,
          "R1 in reset", {sram_addr, sram_ce_n, sram_we_n, sram_oe_n, host_dout_en}, 18'h0 << 4 | 4'hE);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sram_addr == 0 && sram_we_n && sram_oe_n && !host_dout_en,
          "R1 after reset", sram_addr, 0);

    // R2 R3 R4: table walk
    for (int i = 0; i < 8; i++) begin
      logic [29:0] v;
      v = VEC[i];
      do_load(v[28:26], v[25:24], v[23:16], v[15:8]);
      if (v[29]) do_write(v[7:0]);
      else       do_read();
    end

    // R9: two writes under one write command
    begin
      int w0;
      w0 = wcnt;
      pstrobe(1'b0, 8'h04);
      pstrobe(1'b1, 8'h11);
      pstrobe(1'b1, 8'h22);
      check(wcnt == w0 + 2, "R9 repeated command", wcnt - w0, 2);
      check(cap_data == 8'h22, "R9 second data", cap_data, 8'h22);
      check(cap_addr == exp_addr, "R9 address kept", cap_addr, exp_addr);
    end

    // R8: ignored codes
    begin
      logic [7:0] bad [0:2];
      bad = '{8'h00, 8'h06, 8'hFF};
      for (int k = 0; k < 3; k++) begin
        int w0, d0;
        w0 = wcnt; d0 = drv_cnt;
        pstrobe(1'b0, bad[k]);
        @(negedge clk); host_sel = 1'b1; host_din = 8'h77;
        @(negedge clk); host_stb = 1'b1;
        repeat (4) @(negedge clk);
        check(!host_dout_en, "R8 no drive during strobe", host_dout_en, 0);
        host_stb = 1'b0;
        repeat (6) @(negedge clk);
        check(sram_addr == exp_addr, "R8 address unchanged", sram_addr, exp_addr);
        check(wcnt == w0 && drv_cnt == d0, "R8 no RAM cycle", wcnt - w0 + drv_cnt - d0, 0);
      end
    end

    // R2 R3: reload low byte and top bits after ignored codes, read back
    do_load(3'b101, 2'b10, 8'h00, 8'h01);
    do_read();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule